// File: doc/BRIEF.md
# Prioritised Trigger and Event Link Word Arbiter

This block feeds one fixed-width link word per bunch crossing to a serial link. Two sources share that link. The first is the stream of trigger stub packets; one packet may arrive every crossing. The second is a stream of event words read out after a first-level accept.

Each source writes into its own queue. Every word the block sends carries a valid bit and a type bit. The trigger queue holds whole packets. Each packet becomes a header word, which carries the crossing time stamp, the stub count and a truncation marker, followed by the stubs packed six to a word.

Service is strictly ordered. Trigger words go out first, and the words of one packet are always sent back to back. An event word goes out only when the trigger queue is completely empty. A run of event words can therefore be cut at any word boundary, and it carries on once the trigger data has drained.

The trigger queue never accepts part of a packet. When the queue is full, the arriving packet is discarded whole, an overflow counter advances, and the next packet that is accepted carries the truncation marker.

Top module: `link_arb_top`

## Requirements
- R1: While `rst` is high at a rising edge, the next `link_word` is all zeros. After that edge, `trg_level`, `ev_level` and `ovf_count` read 0 and `ev_full` reads 0.
- R2: In a cycle with no trigger word and no event word to send, `link_word` is all zeros. This idle word is the only word with bit 79 clear.
- R3: A trigger header word has bits [79:77]=3'b111. Bit 76 is the truncation marker, [75:68] the time stamp, [67:63] the stored stub count, and all other bits are zero.
- R4: The stub words of a packet follow its header directly. Each has bits [79:77]=3'b110. Stub k of the packet sits in stub word k/6, in slot j=k%6, at bits [12j+11:12j]. Slots past the count, and bits [76:72], are zero. A packet with count 0 sends only its header.
- R5: A stub count offered above 16 is stored and reported as 16, and only the first 16 stubs are sent.
- R6: An event word is sent only if `trg_level` was 0 and no trigger packet was part-way out at the edge that produced it. Once a header is sent, its stub words fill the following cycles with nothing in between.
- R7: An event word has bits [79:78]=2'b10 and carries the 78-bit event input in bits [77:0]. Event words leave in the order they were accepted, including across trigger interruptions.
- R8: The trigger queue holds at most 8 packets. `trg_level` counts the packets accepted but not yet started. A packet offered while `trg_level` is 8 is discarded whole, and `ovf_count` rises by one (it saturates at all ones).
- R9: After one or more discards, the next accepted packet has its truncation marker set. The packets accepted after that have it clear.
- R10: The event queue holds at most 16 words. `ev_full` is high exactly when `ev_level` is 16. An event word offered while the queue is full is ignored and never appears on the link.
- R11: A packet offered to an idle, empty block at rising edge E appears as its header on `link_word` after edge E+2. The word after edge E+1 is still idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| trg_in_valid | input | 1 | A trigger packet is offered this cycle |
| trg_in_ts | input | 8 | Time stamp of the offered packet |
| trg_in_cnt | input | 5 | Stub count of the offered packet |
| trg_in_stubs | input | 192 | Stubs, stub k at bits [12k+11:12k] |
| ev_in_valid | input | 1 | An event word is offered this cycle |
| ev_in_data | input | 78 | Event word payload |
| link_word | output | 80 | Registered word sent to the link this crossing |
| trg_level | output | 4 | Packets waiting in the trigger queue |
| ev_level | output | 5 | Words waiting in the event queue |
| ev_full | output | 1 | Event queue full |
| ovf_count | output | 16 | Count of discarded trigger packets |

## Verification
Some internal faults show up quickly at the ports. A stuck priority decision or a wrong count of outstanding stub words shows up in the same cycle: an event or idle word appears where a stub word belongs, or a header appears early. A queue pointer or level fault first shows on `trg_level`, `ev_level` or `ev_full` within one cycle. It then appears as a reordered or repeated payload once that entry reaches the head, which can be up to a queue depth later.

A lost truncation marker stays hidden until the next accepted packet is sent. The bench therefore compares every output on every cycle against its own model.

// File: rtl/link_arb_pkg.sv
package link_arb_pkg;

  // Two top bits of every link word: valid, then type (1 = trigger).
  typedef enum logic [1:0] {
    LW_IDLE = 2'b00,
    LW_EVT  = 2'b10,
    LW_TRG  = 2'b11
  } lw_kind_e;

  // Third bit of a trigger word: 1 = header, 0 = stub word.
  localparam logic LW_HDR  = 1'b1;
  localparam logic LW_STUB = 1'b0;

endpackage

// File: rtl/lnk_fifo.sv
module lnk_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [W-1:0]                 wr_data,
  input  logic                         rd_en,
  output logic [W-1:0]                 rd_data,
  output logic                         rd_valid,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  output logic                         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [LW-1:0] mcnt;
  logic          wr_ok, load;

  assign level = mcnt + LW'(rd_valid);
  assign full  = (level == LW'(DEPTH));
  assign wr_ok = wr_en && !full;
  assign load  = (!rd_valid || rd_en) && (mcnt != '0);

  // Storage without reset and registered read so block RAM fits.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (load) rd_data <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      mcnt     <= '0;
      rd_valid <= 1'b0;
    end else begin
      if (wr_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + AW'(1);
      if (load)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + AW'(1);
      mcnt <= mcnt + LW'(wr_ok) - LW'(load);
      if (load)       rd_valid <= 1'b1;
      else if (rd_en) rd_valid <= 1'b0;
    end
  end

  p_level_bound_r8: assert property (@(posedge clk) disable iff (rst)
    level <= LW'(DEPTH))
    else $error("queue level above depth");

  p_pop_valid_r7: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> rd_valid)
    else $error("pop from empty head");

endmodule

// File: rtl/trg_packer.sv
module trg_packer #(
  parameter int TS_W      = 8,
  parameter int STUB_W    = 12,
  parameter int MAX_STUBS = 16,
  parameter int OVF_W     = 16
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic                                          in_valid,
  input  logic [TS_W-1:0]                               in_ts,
  input  logic [$clog2(MAX_STUBS+1)-1:0]                in_cnt,
  input  logic [MAX_STUBS*STUB_W-1:0]                   in_stubs,
  input  logic                                          fifo_full,
  output logic                                          wr_en,
  output logic [1+TS_W+$clog2(MAX_STUBS+1)+MAX_STUBS*STUB_W-1:0] wr_entry,
  output logic [OVF_W-1:0]                              ovf_count
);

  localparam int CNT_W = $clog2(MAX_STUBS + 1);

  logic             trunc_pending;
  logic             drop;
  logic [CNT_W-1:0] cnt_eff;

  assign cnt_eff  = (in_cnt > CNT_W'(MAX_STUBS)) ? CNT_W'(MAX_STUBS) : in_cnt;
  assign drop     = in_valid && fifo_full;
  assign wr_en    = in_valid && !fifo_full;
  assign wr_entry = {trunc_pending, in_ts, cnt_eff, in_stubs};

  always_ff @(posedge clk) begin
    if (rst) begin
      trunc_pending <= 1'b0;
      ovf_count     <= '0;
    end else if (drop) begin
      trunc_pending <= 1'b1;
      if (ovf_count != '1) ovf_count <= ovf_count + OVF_W'(1);
    end else if (wr_en) begin
      trunc_pending <= 1'b0;
    end
  end

  p_ovf_step_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && fifo_full && ovf_count != '1) |=> ovf_count == $past(ovf_count) + OVF_W'(1))
    else $error("discard not counted");

  p_trunc_once_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !fifo_full) |=> !trunc_pending)
    else $error("truncation marker not consumed");

endmodule

// File: rtl/link_word_mux.sv
module link_word_mux
  import link_arb_pkg::*;
#(
  parameter int LINK_W    = 80,
  parameter int TS_W      = 8,
  parameter int STUB_W    = 12,
  parameter int MAX_STUBS = 16,
  parameter int TLVL_W    = 4
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic [1+TS_W+$clog2(MAX_STUBS+1)+MAX_STUBS*STUB_W-1:0] trg_entry,
  input  logic                                          trg_valid,
  input  logic [TLVL_W-1:0]                             trg_level,
  input  logic [LINK_W-3:0]                             ev_data,
  input  logic                                          ev_valid,
  output logic                                          trg_pop,
  output logic                                          ev_pop,
  output logic [LINK_W-1:0]                             link_word
);

  localparam int CNT_W   = $clog2(MAX_STUBS + 1);
  localparam int STUBS_W = MAX_STUBS * STUB_W;
  localparam int SPW     = (LINK_W - 3) / STUB_W;
  localparam int SEL_W   = $clog2(STUBS_W);
  localparam int HDR_TS  = LINK_W - 5;
  localparam int HDR_CNT = LINK_W - 5 - TS_W;

  logic               e_trunc;
  logic [TS_W-1:0]    e_ts;
  logic [CNT_W-1:0]   e_cnt, e_nw;
  logic [STUBS_W-1:0] e_stubs;

  logic               tp_active;
  logic [CNT_W-1:0]   tp_idx, tp_nw, tp_cnt;
  logic [STUBS_W-1:0] tp_stubs;

  logic [LINK_W-1:0]  hdr_word, stub_word, evt_word;

  assign e_trunc = trg_entry[STUBS_W+CNT_W+TS_W];
  assign e_ts    = trg_entry[STUBS_W+CNT_W +: TS_W];
  assign e_cnt   = trg_entry[STUBS_W +: CNT_W];
  assign e_stubs = trg_entry[STUBS_W-1:0];
  assign e_nw    = CNT_W'((int'(e_cnt) + SPW - 1) / SPW);

  assign trg_pop = !tp_active && trg_valid;
  assign ev_pop  = !tp_active && (trg_level == '0) && ev_valid;

  always_comb begin
    hdr_word = '0;
    hdr_word[LINK_W-1 -: 2]      = LW_TRG;
    hdr_word[LINK_W-3]           = LW_HDR;
    hdr_word[LINK_W-4]           = e_trunc;
    hdr_word[HDR_TS -: TS_W]     = e_ts;
    hdr_word[HDR_CNT -: CNT_W]   = e_cnt;
  end

  always_comb begin
    evt_word = {LW_EVT, ev_data};
  end

  always_comb begin
    stub_word = '0;
    stub_word[LINK_W-1 -: 2] = LW_TRG;
    stub_word[LINK_W-3]      = LW_STUB;
    for (int j = 0; j < SPW; j++) begin
      int k;
      k = int'(tp_idx) * SPW + j;
      if (k < int'(tp_cnt) && k < MAX_STUBS)
        stub_word[j*STUB_W +: STUB_W] = tp_stubs[SEL_W'(k*STUB_W) +: STUB_W];
    end
  end

  always_ff @(posedge clk) begin
    if (trg_pop) begin
      tp_cnt   <= e_cnt;
      tp_stubs <= e_stubs;
      tp_nw    <= e_nw;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      link_word <= '0;
      tp_active <= 1'b0;
      tp_idx    <= '0;
    end else if (tp_active) begin
      link_word <= stub_word;
      tp_idx    <= tp_idx + CNT_W'(1);
      if (tp_idx + CNT_W'(1) == tp_nw) tp_active <= 1'b0;
    end else if (trg_valid) begin
      link_word <= hdr_word;
      tp_idx    <= '0;
      tp_active <= (e_nw != '0);
    end else if (ev_pop) begin
      link_word <= evt_word;
    end else begin
      link_word <= '0;
    end
  end

  p_evt_gap_r6: assert property (@(posedge clk) disable iff (rst)
    (link_word[LINK_W-1 -: 2] == LW_EVT) |-> ($past(trg_level) == '0))
    else $error("event word sent with trigger data waiting");

  p_stub_follow_r4: assert property (@(posedge clk) disable iff (rst)
    tp_active |=> (link_word[LINK_W-1 -: 3] == {LW_TRG, LW_STUB}))
    else $error("stub word missing after header");

  p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
    !link_word[LINK_W-1] |-> (link_word == '0))
    else $error("idle word not all zeros");

endmodule

// File: rtl/link_arb_top.sv
module link_arb_top #(
  parameter int LINK_W    = 80,
  parameter int TS_W      = 8,
  parameter int STUB_W    = 12,
  parameter int MAX_STUBS = 16,
  parameter int TRG_DEPTH = 8,
  parameter int EV_DEPTH  = 16,
  parameter int OVF_W     = 16
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               trg_in_valid,
  input  logic [TS_W-1:0]                    trg_in_ts,
  input  logic [$clog2(MAX_STUBS+1)-1:0]     trg_in_cnt,
  input  logic [MAX_STUBS*STUB_W-1:0]        trg_in_stubs,
  input  logic                               ev_in_valid,
  input  logic [LINK_W-3:0]                  ev_in_data,
  output logic [LINK_W-1:0]                  link_word,
  output logic [$clog2(TRG_DEPTH+1)-1:0]     trg_level,
  output logic [$clog2(EV_DEPTH+1)-1:0]      ev_level,
  output logic                               ev_full,
  output logic [OVF_W-1:0]                   ovf_count
);

  localparam int CNT_W   = $clog2(MAX_STUBS + 1);
  localparam int ENTRY_W = 1 + TS_W + CNT_W + MAX_STUBS * STUB_W;
  localparam int TLVL_W  = $clog2(TRG_DEPTH + 1);
  localparam int EV_W    = LINK_W - 2;

  logic               tq_wr, tq_full, tq_valid, tq_pop;
  logic [ENTRY_W-1:0] tq_wdata, tq_rdata;
  logic               eq_valid, eq_pop;
  logic [EV_W-1:0]    eq_rdata;

  trg_packer #(
    .TS_W(TS_W), .STUB_W(STUB_W), .MAX_STUBS(MAX_STUBS), .OVF_W(OVF_W)
  ) u_packer (
    .clk(clk), .rst(rst),
    .in_valid(trg_in_valid), .in_ts(trg_in_ts), .in_cnt(trg_in_cnt),
    .in_stubs(trg_in_stubs), .fifo_full(tq_full),
    .wr_en(tq_wr), .wr_entry(tq_wdata), .ovf_count(ovf_count)
  );

  lnk_fifo #(.W(ENTRY_W), .DEPTH(TRG_DEPTH)) u_trg_q (
    .clk(clk), .rst(rst),
    .wr_en(tq_wr), .wr_data(tq_wdata),
    .rd_en(tq_pop), .rd_data(tq_rdata), .rd_valid(tq_valid),
    .level(trg_level), .full(tq_full)
  );

  lnk_fifo #(.W(EV_W), .DEPTH(EV_DEPTH)) u_ev_q (
    .clk(clk), .rst(rst),
    .wr_en(ev_in_valid), .wr_data(ev_in_data),
    .rd_en(eq_pop), .rd_data(eq_rdata), .rd_valid(eq_valid),
    .level(ev_level), .full(ev_full)
  );

  link_word_mux #(
    .LINK_W(LINK_W), .TS_W(TS_W), .STUB_W(STUB_W),
    .MAX_STUBS(MAX_STUBS), .TLVL_W(TLVL_W)
  ) u_mux (
    .clk(clk), .rst(rst),
    .trg_entry(tq_rdata), .trg_valid(tq_valid), .trg_level(trg_level),
    .ev_data(eq_rdata), .ev_valid(eq_valid),
    .trg_pop(tq_pop), .ev_pop(eq_pop), .link_word(link_word)
  );

  p_full_level_r10: assert property (@(posedge clk) disable iff (rst)
    ev_full |=> (ev_level >= $past(ev_level) - 1))
    else $error("event queue lost words while full");

endmodule

// File: tb/link_arb_top_tb.sv
module link_arb_top_tb;

  localparam int CLK_PERIOD = 10;
  localparam int TD = 8;
  localparam int ED = 16;
  localparam int WD_LIMIT = 60000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         trg_in_valid = 1'b0;
  logic [7:0]   trg_in_ts = '0;
  logic [4:0]   trg_in_cnt = '0;
  logic [191:0] trg_in_stubs = '0;
  logic         ev_in_valid = 1'b0;
  logic [77:0]  ev_in_data = '0;
  logic [79:0]  link_word;
  logic [3:0]   trg_level;
  logic [4:0]   ev_level;
  logic         ev_full;
  logic [15:0]  ovf_count;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_arb_top u_dut (
    .clk(clk), .rst(rst),
    .trg_in_valid(trg_in_valid), .trg_in_ts(trg_in_ts), .trg_in_cnt(trg_in_cnt),
    .trg_in_stubs(trg_in_stubs), .ev_in_valid(ev_in_valid), .ev_in_data(ev_in_data),
    .link_word(link_word), .trg_level(trg_level), .ev_level(ev_level),
    .ev_full(ev_full), .ovf_count(ovf_count)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  typedef struct {
    logic         tr;
    logic [7:0]   ts;
    int           cnt;
    logic [191:0] st;
  } pkt_t;

  pkt_t        tq[$];
  logic [77:0] eq[$];
  pkt_t        thead, mpkt;
  bit          thv, ehv, mact, pend, armed;
  logic [77:0] ehead;
  int          midx, mnw, movf;
  logic [79:0] exp_word;
  int          exp_tlev, exp_elev;

  function automatic logic [79:0] hdr_of(pkt_t p);
    logic [79:0] w = '0;
    w[79:77] = 3'b111;
    w[76]    = p.tr;
    w[75:68] = p.ts;
    w[67:63] = 5'(p.cnt);
    return w;
  endfunction

  function automatic logic [79:0] stub_of(pkt_t p, int idx);
    logic [79:0] w = '0;
    w[79:77] = 3'b110;
    for (int j = 0; j < 6; j++) begin
      int k = idx * 6 + j;
      if (k < p.cnt) w[12*j +: 12] = p.st[12*k +: 12];
    end
    return w;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      tq.delete(); eq.delete();
      thv = 0; ehv = 0; mact = 0; pend = 0; movf = 0;
      exp_word = '0; armed = 1;
    end else begin
      int tl, el;
      bit tpop, epop;
      tl = tq.size() + int'(thv);
      el = eq.size() + int'(ehv);
      tpop = 0; epop = 0;
      if (mact) begin
        exp_word = stub_of(mpkt, midx);
        midx++;
        if (midx == mnw) mact = 0;
      end else if (thv) begin
        tpop = 1;
        exp_word = hdr_of(thead);
        mnw = (thead.cnt + 5) / 6;
        if (mnw > 0) begin mact = 1; midx = 0; mpkt = thead; end
      end else if (tl == 0 && ehv) begin
        epop = 1;
        exp_word = {2'b10, ehead};
      end else begin
        exp_word = '0;
      end
      if (!thv || tpop) begin
        if (tq.size() > 0) begin thead = tq.pop_front(); thv = 1; end else thv = 0;
      end
      if (!ehv || epop) begin
        if (eq.size() > 0) begin ehead = eq.pop_front(); ehv = 1; end else ehv = 0;
      end
      if (trg_in_valid) begin
        if (tl == TD) begin
          if (movf < 65535) movf++;
          pend = 1;
        end else begin
          pkt_t p;
          p.tr = pend; pend = 0;
          p.ts = trg_in_ts;
          p.cnt = (trg_in_cnt > 16) ? 16 : int'(trg_in_cnt);
          p.st = trg_in_stubs;
          tq.push_back(p);
        end
      end
      if (ev_in_valid && el < ED) eq.push_back(ev_in_data);
    end
    exp_tlev = tq.size() + int'(thv);
    exp_elev = eq.size() + int'(ehv);
  end

  // ---------------- per-cycle comparison ----------------
  bit saw_trunc = 0, saw_clamp = 0, saw_full = 0, saw_resume = 0;
  bit had_ev = 0, trg_after_ev = 0;
  bit cmp_on = 0;

  always @(negedge clk) begin
    if (cmp_on && armed) begin
      string tag;
      if (!exp_word[79])      tag = "R2 idle word";
      else if (!exp_word[78]) tag = "R6 R7 event word";
      else if (exp_word[77])  tag = "R3 R5 R9 header word";
      else                    tag = "R4 stub word";
      chk(link_word === exp_word, tag, link_word, exp_word);
      chk(int'(trg_level) == exp_tlev, "R8 trg_level", 80'(trg_level), 80'(exp_tlev));
      chk(int'(ev_level) == exp_elev, "R10 ev_level", 80'(ev_level), 80'(exp_elev));
      chk(ev_full === (exp_elev == ED), "R10 ev_full", 80'(ev_full), 80'(exp_elev == ED));
      chk(int'(ovf_count) == movf, "R8 ovf_count", 80'(ovf_count), 80'(movf));
      if (link_word[79:77] == 3'b111 && link_word[76]) saw_trunc = 1;
      if (link_word[79:77] == 3'b111 && link_word[67:63] == 5'd16) saw_clamp = 1;
      if (ev_full) saw_full = 1;
      if (link_word[79:78] == 2'b10) begin
        if (had_ev && trg_after_ev) saw_resume = 1;
        had_ev = 1; trg_after_ev = 0;
      end else if (link_word[79:78] == 2'b11 && had_ev) begin
        trg_after_ev = 1;
      end
    end
  end

  // ---------------- stimulus ----------------
  int ts_ctr = 0;

  task automatic step(input bit tv, input int tcnt, input bit ev);
    trg_in_valid = tv;
    trg_in_ts    = 8'(ts_ctr);
    ts_ctr++;
    trg_in_cnt   = 5'(tcnt);
    for (int i = 0; i < 6; i++) trg_in_stubs[32*i +: 32] = $urandom;
    ev_in_valid  = ev;
    ev_in_data   = {14'($urandom), $urandom, $urandom};
    @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_LIMIT) begin
      tests++; fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected<%0d", cyc, WD_LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(link_word === '0, "R1 reset link_word", link_word, '0);
    chk(trg_level === '0 && ev_level === '0, "R1 reset levels", 80'({trg_level, ev_level}), '0);
    chk(ev_full === 1'b0 && ovf_count === '0, "R1 reset status", 80'({ev_full, ovf_count}), '0);
    rst = 1'b0;
    cmp_on = 1;
    repeat (2) step(0, 0, 0);

    // R11: latency of a lone packet with 7 stubs
    step(1, 7, 0);
    chk(link_word === '0, "R11 idle after capture edge", link_word, '0);
    step(0, 0, 0);
    chk(link_word === '0, "R11 idle after second edge", link_word, '0);
    step(0, 0, 0);
    chk(link_word[79:77] === 3'b111 && link_word[67:63] === 5'd7, "R11 header on third edge",
        link_word, 80'h0);
    repeat (6) step(0, 0, 0);

    // R4: count 0 sends header only
    step(1, 0, 0);
    repeat (6) step(0, 0, 0);

    // R5: clamp
    step(1, 20, 0);
    repeat (8) step(0, 0, 0);

    // R7/R6: events, interrupted by triggers
    step(1, 16, 1);
    repeat (6) step(0, 0, 1);
    step(1, 9, 1);
    repeat (4) step(0, 0, 1);
    repeat (20) step(0, 0, 0);

    // R8/R9/R10: overload
    repeat (40) step(1, 12, 1);
    repeat (200) step(0, 0, 0);

    // random mix
    for (int n = 0; n < 3000; n++)
      step(($urandom % 10) < 3, $urandom % 21, ($urandom % 2) == 1);
    repeat (300) step(0, 0, 0);

    chk(saw_clamp, "R5 clamped header observed", 80'(saw_clamp), 80'(1));
    chk(saw_trunc, "R9 truncation marker observed", 80'(saw_trunc), 80'(1));
    chk(ovf_count != 0, "R8 discards counted", 80'(ovf_count), 80'(movf));
    chk(saw_full, "R10 event queue reached full", 80'(saw_full), 80'(1));
    chk(saw_resume, "R6 R7 event stream resumed after trigger", 80'(saw_resume), 80'(1));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule